// File: doc/BRIEF.md
# Four-Bank Register-Mapped Pin Controller

This block gives software control over 128 general-purpose pins, grouped as four banks of 32. Each bank has a value register and a direction register, reached through a 32-bit word register port with a 256-byte address window. A pin whose direction bit is set is driven from the bank's value register. A pin whose direction bit is clear is left undriven, and its level is sampled from the pad once per clock.

For each bank, a read-only view register returns the merged pin value. Output pins contribute the value register and input pins contribute the sampled pad level. The controller also watches for a pin that is configured as an output while its pad is seen high from outside. It reports that case through a sticky flag, which only reset clears.

Register map: bank b has its value register at byte offset 12·b and its direction register at 12·b+4. The view registers are at 0x50+4·b, and a constant identification word is at 0x64. Any other offset is unmapped.

Top module: `pio_quad_bank`

## Requirements
- R1: While `rst_n` is low and after reset, all value and direction registers are zero. As a result `pin_oe`, `pin_out` and `conflict` are 0, and reads of any bank register return 0.
- R2: A write with `req=1, wr=1` to offset 12·b updates bank b's value register, and a write to offset 12·b+4 updates its direction register. A read with `req=1, wr=0` presents the addressed register on `rdata` in the cycle after the request, and `rdata` holds it until the next read.
- R3: A direction bit of 1 makes the pin an output: its `pin_oe` bit is 1 and its `pin_out` bit equals the value register bit. A direction bit of 0 gives `pin_oe`=0 and `pin_out`=0.
- R4: `pin_in` is registered once per clock. The view register of bank b at 0x50+4·b returns (value AND direction) OR (sampled input AND NOT direction).
- R5: Writes to the view registers and to the identification word change no register.
- R6: The identification word at 0x64 always reads as zero.
- R7: If any pin has its direction bit at 1 while its sampled input is 1, `conflict` rises on the clock after that sample. It then stays 1 until reset.
- R8: A read of an unmapped offset returns zero, with `bad_access` high for exactly the cycle in which that `rdata` is presented. Unmapped offsets include any address with bits [1:0] not zero, 0x08, 0x30 to 0x4c, 0x60 and 0x68 and above. Writes to unmapped offsets change no register.
- R9: A write to one bank leaves the registers of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after a read request |
| bad_access | output | 1 | Pulse when an unmapped read is answered |
| pin_in | input | 128 | Pad input levels, bank b at bits [32b+31:32b] |
| pin_out | output | 128 | Pad output values |
| pin_oe | output | 128 | Pad output enables |
| conflict | output | 1 | Sticky output-versus-external-drive error |

## Verification
The hardest state to reach from the ports is the merged view of one bank that holds outputs and inputs at the same time. In that state the sampled pad levels must land only on input positions and never provoke the conflict flag. The stimulus reaches it by choosing a direction mask, then raising `pin_in` only on the cleared direction bits and waiting two clocks for the sample to settle before reading the view register. The conflict itself is tested last, because its flag is sticky. A high pad is driven on an output pin, then removed, and the flag is checked to survive until a second reset.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned NUM_BANKS   = 4;
  localparam int unsigned BANK_W      = 32;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned BANK_STRIDE = 12;
  localparam int unsigned DIR_OFFSET  = 4;
  localparam int unsigned VIEW_BASE   = 'h50;
  localparam int unsigned VIEW_STRIDE = 4;
  localparam int unsigned IDENT_ADDR  = 'h64;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VALUE,
    SEL_DIR,
    SEL_VIEW,
    SEL_IDENT
  } sel_kind_e;
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_pkg::*;
#(
  parameter int unsigned P_BANKS  = NUM_BANKS,
  parameter int unsigned P_ADDR_W = ADDR_W,
  localparam int unsigned IDX_W   = (P_BANKS > 1) ? $clog2(P_BANKS) : 1
) (
  input  logic [P_ADDR_W-1:0] addr,
  output sel_kind_e           kind,
  output logic [IDX_W-1:0]    idx
);
  always_comb begin
    kind = SEL_NONE;
    idx  = '0;
    if (addr[1:0] == 2'b00) begin
      for (int b = 0; b < P_BANKS; b++) begin
        if (addr == P_ADDR_W'(b * BANK_STRIDE)) begin
          kind = SEL_VALUE;
          idx  = IDX_W'(b);
        end
        if (addr == P_ADDR_W'(b * BANK_STRIDE + DIR_OFFSET)) begin
          kind = SEL_DIR;
          idx  = IDX_W'(b);
        end
        if (addr == P_ADDR_W'(VIEW_BASE + b * VIEW_STRIDE)) begin
          kind = SEL_VIEW;
          idx  = IDX_W'(b);
        end
      end
      if (addr == P_ADDR_W'(IDENT_ADDR)) begin
        kind = SEL_IDENT;
      end
    end
  end
endmodule

// File: rtl/pio_bank_regs.sv
module pio_bank_regs #(
  parameter int unsigned P_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_value_en,
  input  logic           wr_dir_en,
  input  logic [P_W-1:0] wdata,
  input  logic [P_W-1:0] pin_in,
  output logic [P_W-1:0] value_q,
  output logic [P_W-1:0] dir_q,
  output logic [P_W-1:0] merged,
  output logic [P_W-1:0] pin_out,
  output logic [P_W-1:0] pin_oe,
  output logic           clash
);
  logic [P_W-1:0] value_d, dir_d, samp_q;

  // next-state
  always_comb begin
    value_d = value_q;
    dir_d   = dir_q;
    if (wr_value_en) value_d = wdata;
    if (wr_dir_en)   dir_d   = wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      dir_q   <= '0;
      samp_q  <= '0;
    end else begin
      value_q <= value_d;
      dir_q   <= dir_d;
      samp_q  <= pin_in;
    end
  end

  assign merged  = (value_q & dir_q) | (samp_q & ~dir_q);
  assign pin_oe  = dir_q;
  assign pin_out = value_q & dir_q;
  assign clash   = |(dir_q & samp_q);

  p_value_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_value_en |=> value_q == $past(wdata));
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_en |=> dir_q == $past(wdata));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_value_en && !wr_dir_en) |=> ($stable(value_q) && $stable(dir_q)));
endmodule

// File: rtl/pio_read_path.sv
module pio_read_path
  import pio_pkg::*;
#(
  parameter int unsigned P_BANKS = NUM_BANKS,
  parameter int unsigned P_W     = BANK_W,
  localparam int unsigned IDX_W  = (P_BANKS > 1) ? $clog2(P_BANKS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  sel_kind_e                     kind,
  input  logic [IDX_W-1:0]              idx,
  input  logic [P_BANKS-1:0][P_W-1:0]   value_all,
  input  logic [P_BANKS-1:0][P_W-1:0]   dir_all,
  input  logic [P_BANKS-1:0][P_W-1:0]   merged_all,
  output logic [P_W-1:0]                rdata,
  output logic                          bad_access
);
  logic [P_W-1:0] sel_word, rdata_d;
  logic           bad_d;

  always_comb begin
    sel_word = '0;
    unique case (kind)
      SEL_VALUE: sel_word = value_all[idx];
      SEL_DIR:   sel_word = dir_all[idx];
      SEL_VIEW:  sel_word = merged_all[idx];
      default:   sel_word = '0;
    endcase
    rdata_d = rd_en ? sel_word : rdata;
    bad_d   = rd_en && (kind == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata      <= '0;
      bad_access <= 1'b0;
    end else begin
      rdata      <= rdata_d;
      bad_access <= bad_d;
    end
  end

  p_bad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> rdata == '0);
  p_ident_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && kind == SEL_IDENT) |=> rdata == '0);
endmodule

// File: rtl/pio_quad_bank.sv
module pio_quad_bank
  import pio_pkg::*;
#(
  parameter int unsigned P_BANKS  = NUM_BANKS,
  parameter int unsigned P_W      = BANK_W,
  parameter int unsigned P_ADDR_W = ADDR_W,
  localparam int unsigned PINS    = P_BANKS * P_W,
  localparam int unsigned IDX_W   = (P_BANKS > 1) ? $clog2(P_BANKS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                wr,
  input  logic [P_ADDR_W-1:0] addr,
  input  logic [P_W-1:0]      wdata,
  output logic [P_W-1:0]      rdata,
  output logic                bad_access,
  input  logic [PINS-1:0]     pin_in,
  output logic [PINS-1:0]     pin_out,
  output logic [PINS-1:0]     pin_oe,
  output logic                conflict
);
  sel_kind_e                    kind;
  logic [IDX_W-1:0]             idx;
  logic                         wr_en, rd_en;
  logic [P_BANKS-1:0][P_W-1:0]  value_all, dir_all, merged_all;
  logic [P_BANKS-1:0]           clash_all;
  logic                         conflict_d;

  assign wr_en = req && wr;
  assign rd_en = req && !wr;

  pio_addr_decode #(.P_BANKS(P_BANKS), .P_ADDR_W(P_ADDR_W)) u_dec (
    .addr (addr),
    .kind (kind),
    .idx  (idx)
  );

  for (genvar b = 0; b < P_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(b));
    pio_bank_regs #(.P_W(P_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_value_en (hit && kind == SEL_VALUE),
      .wr_dir_en   (hit && kind == SEL_DIR),
      .wdata       (wdata),
      .pin_in      (pin_in[b*P_W +: P_W]),
      .value_q     (value_all[b]),
      .dir_q       (dir_all[b]),
      .merged      (merged_all[b]),
      .pin_out     (pin_out[b*P_W +: P_W]),
      .pin_oe      (pin_oe[b*P_W +: P_W]),
      .clash       (clash_all[b])
    );
  end

  pio_read_path #(.P_BANKS(P_BANKS), .P_W(P_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .kind       (kind),
    .idx        (idx),
    .value_all  (value_all),
    .dir_all    (dir_all),
    .merged_all (merged_all),
    .rdata      (rdata),
    .bad_access (bad_access)
  );

  // sticky conflict flag
  assign conflict_d = conflict | (|clash_all);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict <= 1'b0;
    else        conflict <= conflict_d;
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> conflict);
  p_bad_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (bad_access == ($past(kind) == SEL_NONE)));
  p_view_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (kind == SEL_VIEW || kind == SEL_IDENT || kind == SEL_NONE))
      |=> ($stable(value_all) && $stable(dir_all)));
endmodule

// File: tb/pio_quad_bank_test.sv
module pio_quad_bank_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, wr = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         bad_access;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic         conflict;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] exp_data[$];
  logic        exp_bad[$];
  string       exp_tag[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_quad_bank uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bad_access(bad_access),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .conflict(conflict)
  );

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each read response against the scoreboard queue
  always @(posedge clk) rd_seen <= rst_n && req && !wr;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_data.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected read response %h", rdata);
      end else begin
        logic [31:0] d; logic b; string t;
        d = exp_data.pop_front(); b = exp_bad.pop_front(); t = exp_tag.pop_front();
        check(t, {96'd0, rdata}, {96'd0, d});
        check({t, " bad_access"}, {127'd0, bad_access}, {127'd0, b});
      end
    end else if (rst_n) begin
      if (bad_access !== 1'b0) begin
        checks++; errors++;
        $display("FAIL R8: bad_access actual %b expected 0 outside a read", bad_access);
      end
    end
  end

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, logic [31:0] d, logic b, string tag);
    @(negedge clk);
    exp_data.push_back(d); exp_bad.push_back(b); exp_tag.push_back(tag);
    req = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: state while in reset
    check("R1 oe in reset", pin_oe, '0);
    check("R1 conflict in reset", {127'd0, conflict}, '0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    do_read(8'h00, 32'h0, 1'b0, "R1 value0");
    do_read(8'h28, 32'h0, 1'b0, "R1 dir3");
    do_read(8'h50, 32'h0, 1'b0, "R1 view0");

    // R2 / R3: bank0 mixed direction
    do_write(8'h00, 32'h1234_5678);
    do_write(8'h04, 32'h0000_FFFF);
    do_read(8'h00, 32'h1234_5678, 1'b0, "R2 value0");
    do_read(8'h04, 32'h0000_FFFF, 1'b0, "R2 dir0");
    check("R3 oe bank0", {96'd0, pin_oe[31:0]}, {96'd0, 32'h0000_FFFF});
    check("R3 out bank0", {96'd0, pin_out[31:0]}, {96'd0, 32'h0000_5678});

    // bank2 all inputs, bank3 all outputs
    do_write(8'h18, 32'hFFFF_FFFF);
    do_write(8'h2C - 8'h04, 32'hFFFF_FFFF);
    do_write(8'h24, 32'hDEAD_BEEF);
    check("R3 out bank2 inputs", {96'd0, pin_out[95:64]}, '0);
    check("R3 out bank3", {96'd0, pin_out[127:96]}, {96'd0, 32'hDEAD_BEEF});
    check("R3 oe bank3", {96'd0, pin_oe[127:96]}, {96'd0, 32'hFFFF_FFFF});

    // R4: merged views
    @(negedge clk);
    pin_in[31:0]  = 32'hABCD_0000;
    pin_in[95:64] = 32'h0F0F_0F0F;
    idle(2);
    do_read(8'h50, 32'hABCD_5678, 1'b0, "R4 view0 mixed");
    do_read(8'h58, 32'h0F0F_0F0F, 1'b0, "R4 view2 inputs");
    do_read(8'h5C, 32'hDEAD_BEEF, 1'b0, "R4 view3 outputs");
    do_read(8'h54, 32'h0, 1'b0, "R9 view1 untouched");
    do_read(8'h0C, 32'h0, 1'b0, "R9 value1 untouched");
    check("R7 no conflict on inputs", {127'd0, conflict}, '0);

    // R5 / R6: read-only registers
    do_write(8'h50, 32'h5555_5555);
    do_write(8'h64, 32'hFFFF_FFFF);
    do_read(8'h50, 32'hABCD_5678, 1'b0, "R5 view0 after write");
    do_read(8'h00, 32'h1234_5678, 1'b0, "R5 value0 after view write");
    do_read(8'h04, 32'h0000_FFFF, 1'b0, "R5 dir0 after view write");
    do_read(8'h64, 32'h0, 1'b0, "R6 ident");

    // R8: unmapped accesses
    do_read(8'h08, 32'h0, 1'b1, "R8 gap 0x08");
    do_read(8'h30, 32'h0, 1'b1, "R8 0x30");
    do_read(8'h01, 32'h0, 1'b1, "R8 misaligned 0x01");
    do_read(8'h60, 32'h0, 1'b1, "R8 0x60");
    do_read(8'hFC, 32'h0, 1'b1, "R8 0xFC");
    do_write(8'h02, 32'h0BAD_0BAD);
    do_write(8'h08, 32'h0BAD_0BAD);
    do_write(8'h4C, 32'h0BAD_0BAD);
    do_read(8'h00, 32'h1234_5678, 1'b0, "R8 value0 after unmapped writes");
    do_read(8'h04, 32'h0000_FFFF, 1'b0, "R8 dir0 after unmapped writes");

    // R9: write bank1 only
    do_write(8'h0C, 32'hCAFE_F00D);
    do_read(8'h0C, 32'hCAFE_F00D, 1'b0, "R9 value1");
    do_read(8'h00, 32'h1234_5678, 1'b0, "R9 value0 unchanged");
    do_read(8'h24, 32'hDEAD_BEEF, 1'b0, "R9 value3 unchanged");

    // R7: conflict on an output pin, sticky
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    check("R7 not yet set", {127'd0, conflict}, '0);
    @(negedge clk);
    check("R7 set", {127'd0, conflict}, 128'd1);
    pin_in[0] = 1'b0;
    idle(3);
    check("R7 sticky", {127'd0, conflict}, 128'd1);

    // R1: second reset clears everything
    idle(2);
    rst_n = 1'b0;
    #1;
    check("R1 conflict cleared", {127'd0, conflict}, '0);
    check("R1 oe cleared", pin_oe, '0);
    check("R1 out cleared", pin_out, '0);
    @(negedge clk); rst_n = 1'b1;
    do_read(8'h24, 32'h0, 1'b0, "R1 value3 after reset");
    idle(3);
    check("R2 scoreboard drained", {96'd0, 32'(exp_data.size())}, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule